// File: doc/BRIEF.md
# Serial pixel packetizer with embedded syncs

This block turns a parallel pixel stream from a stand-alone imager into a single-wire serial bitstream. Each pixel arrives with a line-valid and a frame-valid flag on a one-cycle pixel strobe. The block emits one bit per shift clock, in fixed slots of 12 clocks. Every slot carries one packet: a start bit of 1, ten payload bits and a stop bit of 0.

In narrow mode the payload holds the eight upper pixel bits plus the two valid flags, sent explicitly. In wide mode it holds all ten pixel bits. Line and frame timing then travel as reserved payload values placed in blanking slots, and real pixels that would look like those values are replaced before they are sent. Every packet is decided one sample late, because the block must know the next sample to mark an edge that is about to happen.

Column binning repeats each active pixel packet two or four times. A test control replaces the stream with a square wave. A sync-only control sends packets whose payload is all zero.

Top module: `pix_serializer`

## Requirements
- R1: Each slot is 12 clocks long and packet bit 0 is sent first: the start bit 1 goes out in slot clock 0, payload bit p (1..10) in slot clock p, and the stop bit 0 in slot clock 11. The first clock after reset is released is slot clock 0. While reset is held, and in the first slot after it, the output carries an idle packet, so `ser_out` is 1 during reset.
- R2: In narrow mode (`mode_wide`=0), payload bits 1..8 carry pixel bits 2..9, bit 9 carries line-valid and bit 10 carries frame-valid, for every sample, active or not.
- R3: In wide mode, payload bits 1..10 carry pixel bits 0..9 of an active sample (line-valid high).
- R4: In wide mode an active pixel whose value is 0, 1, 2 or 3 is sent as 4.
- R5: In wide mode a blanking sample (line-valid low) carries a code. The code is 2 if the previous sample had line-valid high. Otherwise it is 3 if frame-valid fell from the previous sample. Otherwise it is 0 if the next sample raises frame-valid. Otherwise it is 1 if the next sample has line-valid high. Otherwise it is 0.
- R6: In wide mode a real pixel run 1023, 0, 1023 goes out as 1023, 4, 1023, so the reserved frame-start run never comes from pixel data.
- R7: The packet for sample k is computed when the strobe for sample k+1 arrives. It is loaded at the next slot boundary. A slot with no pending packet carries an idle packet with payload 0.
- R8: `bin_sel` 0 sends an active sample's packet once, 1 sends it twice and 2 or 3 sends it four times, in consecutive slots. Blanking packets are always sent once.
- R9: With `sqw_en` high the output is a square wave: 1 in slot clocks 0..5 and 0 in slot clocks 6..11.
- R10: With `sync_only` high, every packet loaded has an all-zero payload, so the stream is 1 followed by eleven zeros in every slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock |
| rst | input | 1 | Synchronous reset, active high |
| pix_stb | input | 1 | One-cycle strobe qualifying the pixel inputs |
| pix_data | input | 10 | Pixel value |
| pix_lv | input | 1 | Line-valid flag of the sample |
| pix_fv | input | 1 | Frame-valid flag of the sample |
| mode_wide | input | 1 | 1 = ten-bit payload with embedded syncs, 0 = eight bits plus flags |
| bin_sel | input | 2 | Active packet repeat: 0 once, 1 twice, 2 or 3 four times |
| sync_only | input | 1 | Send all-zero payload packets only |
| sqw_en | input | 1 | Replace the stream with a square wave |
| ser_out | output | 1 | Serial data, one bit per clock |

## Verification
The hardest situation to reach is a reserved code decision that needs three samples at once. An example is the blanking sample just before frame-valid rises, which must be told apart from a line-end or frame-end blank. A second case is the middle pixel of a 1023, 0, 1023 run. The stimulus builds whole frames from seeded random lengths, with lead-in blanks, in-frame blanks around each line and a forced 1023, 0, 1023 run in the first line. Each of the four codes therefore appears many times at known positions. Strobes fall at a fixed point every four slots, so the bench can predict the slot of every repeated and idle packet under each binning setting.

// File: rtl/pser_pkg.sv
package pser_pkg;
    localparam int PIX_W = 10;
    localparam int PKT_W = PIX_W + 2;
    localparam int CNT_W = $clog2(PKT_W);
    localparam int REP_W = 3;
    localparam int N_RSV = 4;

    localparam logic [PIX_W-1:0] SUBST     = PIX_W'(N_RSV);
    localparam logic [PIX_W-1:0] C_FRM_ON  = PIX_W'(0);
    localparam logic [PIX_W-1:0] C_LIN_ON  = PIX_W'(1);
    localparam logic [PIX_W-1:0] C_LIN_OFF = PIX_W'(2);
    localparam logic [PIX_W-1:0] C_FRM_OFF = PIX_W'(3);

    typedef struct packed {
        logic [PIX_W-1:0] pix;
        logic             lv;
        logic             fv;
    } smp_t;

    typedef struct packed {
        logic [PIX_W-1:0] pl;
        logic [REP_W-1:0] rep;
    } word_t;
endpackage

// File: rtl/pser_track.sv
module pser_track
    import pser_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic stb,
    input  smp_t din,
    output smp_t prv,
    output smp_t cur
);
    typedef struct packed {
        smp_t older;
        smp_t newer;
    } st_t;

    st_t q, d;

    always_comb begin
        d = q;
        if (stb) begin
            d.older = q.newer;
            d.newer = din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign prv = q.older;
    assign cur = q.newer;
endmodule

// File: rtl/pser_encode.sv
module pser_encode
    import pser_pkg::*;
(
    input  smp_t        prv,
    input  smp_t        cur,
    input  smp_t        nxt,
    input  logic        wide,
    input  logic [1:0]  bin_sel,
    output word_t       word
);
    logic [PIX_W-3:0] hi_bits;
    logic [REP_W-1:0] rep_n;

    for (genvar g = 0; g < PIX_W-2; g++) begin : g_narrow
        assign hi_bits[g] = cur.pix[g+2];
    end

    always_comb begin
        case (bin_sel)
            2'd0:    rep_n = REP_W'(1);
            2'd1:    rep_n = REP_W'(2);
            default: rep_n = REP_W'(4);
        endcase
    end

    always_comb begin
        word.rep = cur.lv ? rep_n : REP_W'(1);
        if (!wide)
            word.pl = {cur.fv, cur.lv, hi_bits};
        else if (cur.lv)
            word.pl = (cur.pix < SUBST) ? SUBST : cur.pix;
        else if (prv.lv)
            word.pl = C_LIN_OFF;
        else if (prv.fv && !cur.fv)
            word.pl = C_FRM_OFF;
        else if (!cur.fv && nxt.fv)
            word.pl = C_FRM_ON;
        else if (nxt.lv)
            word.pl = C_LIN_ON;
        else
            word.pl = '0;
    end
endmodule

// File: rtl/pser_slots.sv
module pser_slots
    import pser_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  stb,
    input  word_t word,
    input  logic  sync_only,
    input  logic  sqw_en,
    output logic  ser_out
);
    typedef struct packed {
        logic [CNT_W-1:0] bitc;
        logic [PKT_W-1:0] pkt;
        logic [PIX_W-1:0] cur_pl;
        logic [REP_W-1:0] left;
        word_t            pend;
        logic             pend_vld;
    } st_t;

    st_t  q, d;
    logic take;

    function automatic logic [PKT_W-1:0] mk(input logic [PIX_W-1:0] pl, input logic so);
        mk = so ? PKT_W'(1) : {1'b0, pl, 1'b1};
    endfunction

    always_comb begin
        d    = q;
        take = 1'b0;
        if (q.bitc == CNT_W'(PKT_W-1)) begin
            d.bitc = '0;
            if (q.left != '0) begin
                d.pkt  = mk(q.cur_pl, sync_only);
                d.left = q.left - REP_W'(1);
            end else if (q.pend_vld) begin
                take     = 1'b1;
                d.pkt    = mk(q.pend.pl, sync_only);
                d.cur_pl = q.pend.pl;
                d.left   = q.pend.rep - REP_W'(1);
            end else begin
                d.pkt = mk('0, sync_only);
            end
        end else begin
            d.bitc = q.bitc + CNT_W'(1);
        end
        if (stb) begin
            d.pend     = word;
            d.pend_vld = 1'b1;
        end else if (take) begin
            d.pend_vld = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q     <= '0;
            q.pkt <= PKT_W'(1);
        end else begin
            q <= d;
        end
    end

    assign ser_out = sqw_en ? (q.bitc < CNT_W'(PKT_W/2)) : q.pkt[q.bitc];

    // R1: start bit leads every slot
    a_r1_start_bit: assert property (@(posedge clk) disable iff (rst)
        (q.bitc == '0 && !sqw_en) |-> ser_out);
    // R1: stop bit closes every slot
    a_r1_stop_bit: assert property (@(posedge clk) disable iff (rst)
        (q.bitc == CNT_W'(PKT_W-1) && !sqw_en) |-> !ser_out);
    // R1: slot counter wraps after twelve clocks
    a_r1_slot_wrap: assert property (@(posedge clk) disable iff (rst)
        (q.bitc == CNT_W'(PKT_W-1)) |=> (q.bitc == '0));
    // R8: at most three repeats remain after a load
    a_r8_repeat_bound: assert property (@(posedge clk) disable iff (rst)
        q.left <= REP_W'(3));
    // R10: packet loaded under sync-only has an empty payload
    a_r10_sync_blank: assert property (@(posedge clk) disable iff (rst)
        (q.bitc == '0 && $past(sync_only)) |-> (q.pkt[PKT_W-1:1] == '0));
endmodule

// File: rtl/pix_serializer.sv
module pix_serializer
    import pser_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             pix_stb,
    input  logic [PIX_W-1:0] pix_data,
    input  logic             pix_lv,
    input  logic             pix_fv,
    input  logic             mode_wide,
    input  logic [1:0]       bin_sel,
    input  logic             sync_only,
    input  logic             sqw_en,
    output logic             ser_out
);
    smp_t  din, prv, cur;
    word_t word;

    assign din = '{pix: pix_data, lv: pix_lv, fv: pix_fv};

    pser_track u_track (
        .clk (clk),
        .rst (rst),
        .stb (pix_stb),
        .din (din),
        .prv (prv),
        .cur (cur)
    );

    pser_encode u_enc (
        .prv     (prv),
        .cur     (cur),
        .nxt     (din),
        .wide    (mode_wide),
        .bin_sel (bin_sel),
        .word    (word)
    );

    pser_slots u_slots (
        .clk       (clk),
        .rst       (rst),
        .stb       (pix_stb),
        .word      (word),
        .sync_only (sync_only),
        .sqw_en    (sqw_en),
        .ser_out   (ser_out)
    );

    // R4: an active wide-mode pixel never leaves as a reserved value
    a_r4_pix_floor: assert property (@(posedge clk) disable iff (rst)
        (pix_stb && cur.lv && mode_wide) |-> (word.pl >= SUBST));
    // R8: blanking samples are never repeated
    a_r8_blank_once: assert property (@(posedge clk) disable iff (rst)
        (pix_stb && !cur.lv) |-> (word.rep == REP_W'(1)));
endmodule

// File: tb/sim_pix_serializer.sv
module sim_pix_serializer;
    localparam int K = 120;
    localparam int NS = 2 + 4*K;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pix_stb = 1'b0;
    logic [9:0] pix_data = '0;
    logic       pix_lv = 1'b0, pix_fv = 1'b0;
    logic       mode_wide = 1'b1;
    logic [1:0] bin_sel = 2'd0;
    logic       sync_only = 1'b0, sqw_en = 1'b0;
    logic       ser_out;

    int n_chk = 0, n_fail = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    pix_serializer u0 (
        .clk(clk), .rst(rst), .pix_stb(pix_stb), .pix_data(pix_data),
        .pix_lv(pix_lv), .pix_fv(pix_fv), .mode_wide(mode_wide),
        .bin_sel(bin_sel), .sync_only(sync_only), .sqw_en(sqw_en),
        .ser_out(ser_out)
    );

    always @(posedge clk) cyc <= rst ? 0 : cyc + 1;

    // slot receiver
    logic [11:0] sh;
    logic [11:0] rx [0:1023];
    int bpos = 0, nrx = 0;
    always @(negedge clk) begin
        if (rst) begin
            bpos = 0;
            nrx  = 0;
        end else begin
            sh[bpos] = ser_out;
            if (bpos == 11) begin
                if (nrx < 1024) rx[nrx] = sh;
                nrx++;
                bpos = 0;
            end else begin
                bpos++;
            end
        end
    end

    // stimulus samples
    logic [9:0] spx [0:K-1];
    logic       slv [0:K-1];
    logic       sfv [0:K-1];
    logic       srun [0:K-1];
    int         gj;

    function automatic logic g_lv(int j); return (j < 0) ? 1'b0 : slv[j]; endfunction
    function automatic logic g_fv(int j); return (j < 0) ? 1'b0 : sfv[j]; endfunction
    function automatic logic [9:0] g_px(int j); return (j < 0) ? 10'd0 : spx[j]; endfunction

    function automatic logic [9:0] exp_pl(int j, bit wide);
        logic [9:0] p;
        p = g_px(j);
        if (!wide) return {g_fv(j), g_lv(j), p[9:2]};
        if (g_lv(j)) return (p < 10'd4) ? 10'd4 : p;
        if (g_lv(j-1)) return 10'd2;
        if (g_fv(j-1) && !g_fv(j)) return 10'd3;
        if (!g_fv(j) && g_fv(j+1)) return 10'd0;
        if (g_lv(j+1)) return 10'd1;
        return 10'd0;
    endfunction

    function automatic string exp_tag(int j, bit wide);
        if (!wide) return "R2";
        if (!g_lv(j)) return "R5";
        if (j >= 0 && srun[j]) return "R6";
        if (g_px(j) < 10'd4) return "R4";
        return "R3";
    endfunction

    function automatic logic [9:0] rnd_pix();
        int r;
        r = int'($urandom % 8);
        case (r)
            0, 1, 2, 3: return 10'(r);
            4:          return 10'd1023;
            5:          return 10'd4;
            default:    return 10'($urandom);
        endcase
    endfunction

    task automatic push(logic [9:0] p, logic l, logic f, logic run);
        if (gj < K) begin
            spx[gj] = p; slv[gj] = l; sfv[gj] = f; srun[gj] = run;
            gj++;
        end
    endtask

    task automatic gen(int seed);
        int frame;
        int nb;
        int len;
        void'($urandom(seed));
        gj = 0;
        frame = 0;
        while (gj < K) begin
            nb = 2 + int'($urandom % 2);
            for (int b = 0; b < nb; b++) push(rnd_pix(), 1'b0, 1'b0, 1'b0);
            for (int b = 0; b < 2; b++) push(rnd_pix(), 1'b0, 1'b1, 1'b0);
            for (int ln = 0; ln < 2; ln++) begin
                len = 3 + int'($urandom % 4);
                for (int x = 0; x < len; x++) begin
                    if (frame == 0 && ln == 0 && x < 3)
                        push((x == 1) ? 10'd0 : 10'd1023, 1'b1, 1'b1, x == 1);
                    else
                        push(rnd_pix(), 1'b1, 1'b1, 1'b0);
                end
                for (int b = 0; b < 2; b++) push(rnd_pix(), 1'b0, 1'b1, 1'b0);
            end
            frame++;
        end
    endtask

    task automatic chk(bit ok, string tag, int where, logic [11:0] got, logic [11:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s at %0d: got %h expected %h", tag, where, got, exp);
        end
    endtask

    task automatic at_cycle(int t);
        while (cyc < t) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(ser_out === (sqw_en ? 1'b1 : 1'b1), "R1 reset output", 0, {11'd0, ser_out}, 12'd1);
        @(posedge clk);
        #1;
        rst = 1'b0;
    endtask

    task automatic run_seg(bit wide, logic [1:0] bsel, bit so, int seed);
        logic [11:0] ex  [0:NS-1];
        string       tg  [0:NS-1];
        int rep;
        logic [11:0] pk;
        mode_wide = wide; bin_sel = bsel; sync_only = so; sqw_en = 1'b0;
        gen(seed);
        for (int s = 0; s < NS; s++) begin
            ex[s] = 12'h001;
            tg[s] = so ? "R10" : "R7";
        end
        for (int k = 0; k < K; k++) begin
            rep = g_lv(k-1) ? ((bsel == 2'd0) ? 1 : (bsel == 2'd1) ? 2 : 4) : 1;
            pk  = so ? 12'h001 : {1'b0, exp_pl(k-1, wide), 1'b1};
            for (int r = 0; r < rep; r++) begin
                ex[2+4*k+r] = pk;
                if (!so) tg[2+4*k+r] = (r == 0) ? exp_tag(k-1, wide) : "R8";
            end
        end
        do_reset();
        for (int k = 0; k < K; k++) begin
            at_cycle(12*(1+4*k) + 3);
            pix_data = spx[k]; pix_lv = slv[k]; pix_fv = sfv[k];
            pix_stb = 1'b1;
            @(posedge clk);
            #1;
            pix_stb = 1'b0;
        end
        at_cycle(12*NS + 4);
        chk(nrx >= NS, "R1 slot count", nrx, 12'(nrx), 12'(NS));
        for (int s = 0; s < NS; s++)
            chk(rx[s] === ex[s], tg[s], s, rx[s], ex[s]);
    endtask

    task automatic run_square();
        sqw_en = 1'b1; sync_only = 1'b0;
        do_reset();
        for (int c = 0; c < 48; c++) begin
            @(negedge clk);
            chk(ser_out === ((c % 12) < 6), "R9", c, {11'd0, ser_out}, {11'd0, ((c % 12) < 6)});
        end
        sqw_en = 1'b0;
    endtask

    bit done = 1'b0;

    initial begin
        run_seg(1'b1, 2'd0, 1'b0, 11);
        run_seg(1'b0, 2'd0, 1'b0, 23);
        run_seg(1'b1, 2'd1, 1'b0, 37);
        run_seg(1'b1, 2'd2, 1'b0, 41);
        run_seg(1'b0, 2'd3, 1'b0, 53);
        run_seg(1'b1, 2'd0, 1'b1, 67);
        run_square();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R1 watchdog expired: got hang expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule